// File: doc/BRIEF.md
# Fair-Queuing DRAM Command Arbiter

This block chooses at most one DRAM command per cycle from a small shared transaction buffer in which several threads hold pending work. Each slot presents its owner thread, target bank, row, command kind, arrival stamp, a ready flag from an external timing checker, and a virtual finish-time deadline computed elsewhere. The arbiter serves the ready command with the smallest deadline. Deadlines stand for the time a request would finish on a private memory system scaled to its thread's share, so picking the smallest one gives each thread its share of bandwidth.

Serving only ready commands keeps the data bus busy, but it lets a stream of ready row hits to an open bank block a command with an earlier deadline to that same bank. To bound that blocking, the arbiter tracks for each bank how long it has been open. It learns this from its own grants: an activate opens the bank and a precharge closes it. Once a bank has been open for a set number of cycles (the row-active minimum), only the earliest-deadline pending command for that bank may be issued to it. If that command is not ready, the bank waits for it. Other banks keep being served meanwhile.

The grant is combinational from the slot inputs in the same cycle. The per-bank open-time state updates on the clock edge that ends the cycle of the grant.

Top module: `fq_cmd_arbiter`

## Requirements
- R1: When no slot is both valid and ready, `grant_valid` is 0 and `grant_onehot` is all zero.
- R2: When `grant_valid` is 1, `grant_onehot` has exactly one bit set, `grant_idx` is its position, and `grant_cmd`, `grant_bank`, `grant_row` and `grant_thread` equal that slot's fields.
- R3: Among qualifying slots, the one with the numerically smallest deadline is granted.
- R4: Between slots with equal deadlines, the one with the lower thread ID is granted.
- R5: Between slots with equal deadline and thread, the smaller arrival stamp wins (stamps are compared as plain unsigned numbers). If those are also equal, the lower slot index wins.
- R6: A slot whose ready flag is 0 is never granted, even when it holds the smallest deadline.
- R7: Command codes are 2'b00 activate, 2'b01 read, 2'b10 write and 2'b11 precharge. A granted activate opens its bank. Counting the clock edge that latches the activate as edge 0, the bank stays unlocked up to edge TRAS-1 and becomes locked from edge TRAS onward. An activate to a bank that is already open restarts its count.
- R8: For a locked bank, the only slot that may be granted is the one whose key (deadline, then thread, then arrival stamp, then index) is smallest among all valid slots for that bank, ready or not. If that slot is not ready, no slot for that bank is granted. Ready slots for other banks are still served.
- R9: A granted precharge closes its bank on the closing clock edge. Ready row hits to that bank are then served in deadline order again.
- R10: Synchronous active-low reset closes every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_valid | input | NUM_ENT | Slot holds a pending command |
| ent_ready | input | NUM_ENT | Slot's command meets all timing rules this cycle |
| ent_thread | input | NUM_ENT x THREAD_W | Owner thread per slot |
| ent_bank | input | NUM_ENT x BANK_W | Target bank per slot |
| ent_row | input | NUM_ENT x ROW_W | Target row per slot |
| ent_cmd | input | NUM_ENT x 2 | Command kind per slot |
| ent_arrival | input | NUM_ENT x TS_W | Arrival stamp per slot |
| ent_deadline | input | NUM_ENT x DL_W | Virtual finish-time per slot |
| grant_valid | output | 1 | A command is issued this cycle |
| grant_onehot | output | NUM_ENT | One-hot selected slot |
| grant_idx | output | IDX_W | Index of selected slot |
| grant_cmd | output | 2 | Issued command kind |
| grant_bank | output | BANK_W | Issued bank |
| grant_row | output | ROW_W | Issued row |
| grant_thread | output | THREAD_W | Thread of issued command |

## Verification
The only hidden state is each bank's open flag and its count since activation. An error in that state shows at the ports as a stall that comes one or more cycles early or late once a bank passes TRAS cycles. It can also show as a ready row hit being refused, or a blocked slot being served, right after a precharge or a reset. The bench samples the grant in the cycles just before and just after the lock point, and again after a precharge and after a reset. A wrong count therefore appears as a wrong grant within one cycle of the boundary. Ordering mistakes need no state and appear as a wrong `grant_idx` in the same cycle.

// File: rtl/fq_arb_pkg.sv
// Package: shared encodings for the fair-queuing command arbiter.
// Assumes a 2-bit command field driven by the transaction buffer.
package fq_arb_pkg;
    typedef enum logic [1:0] {
        CMD_ACT = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_PRE = 2'b11
    } fq_cmd_e;
endpackage

// File: rtl/fq_bank_age.sv
// Module: per-bank open-time tracker.
// Watches the arbiter's own grants. An activate opens a bank and restarts its
// count, and a precharge closes it. The count saturates at TRAS, and a bank is
// locked while it is open with a saturated count.
// Assumes the issued command is the only source of bank state changes.
module fq_bank_age #(
    parameter int NUM_BANKS = 8,
    parameter int TRAS      = 18,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CNT_W    = $clog2(TRAS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_valid,
    input  logic [BANK_W-1:0]    upd_bank,
    input  logic [1:0]           upd_cmd,
    output logic [NUM_BANKS-1:0] bank_locked
);
    import fq_arb_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TRAS);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             open_q;
        logic [CNT_W-1:0] cnt_q;
        logic             hit;

        assign hit = upd_valid && (upd_bank == BANK_W'(b));

        // Track open state and saturating age for this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else if (hit && upd_cmd == CMD_ACT) begin
                open_q <= 1'b1;
                cnt_q  <= '0;
            end else if (hit && upd_cmd == CMD_PRE) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else if (open_q && cnt_q != LIMIT) begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end

        assign bank_locked[b] = open_q && (cnt_q == LIMIT);

        // R7
        age_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LIMIT);

        // R9
        pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && upd_cmd == CMD_PRE) |=> !bank_locked[b]);
    end
endmodule

// File: rtl/fq_entry_filter.sv
// Module: per-slot qualification.
// A slot qualifies when it is valid and ready and either its bank is unlocked
// or it is the smallest-key valid slot for that bank (the bank head).
// Assumes keys are unique (the slot index is part of the key).
module fq_entry_filter #(
    parameter int NUM_ENT   = 8,
    parameter int NUM_BANKS = 8,
    parameter int KEY_W     = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_ENT-1:0]             ent_valid,
    input  logic [NUM_ENT-1:0]             ent_ready,
    input  logic [NUM_ENT-1:0][BANK_W-1:0] ent_bank,
    input  logic [NUM_ENT-1:0][KEY_W-1:0]  ent_key,
    input  logic [NUM_BANKS-1:0]           bank_locked,
    output logic [NUM_ENT-1:0]             eligible
);
    logic [NUM_ENT-1:0] is_head;

    // Find, per slot, whether any valid slot of the same bank has a smaller key.
    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            is_head[i] = ent_valid[i];
            for (int j = 0; j < NUM_ENT; j++) begin
                if (j != i && ent_valid[j] && ent_bank[j] == ent_bank[i]
                    && ent_key[j] < ent_key[i])
                    is_head[i] = 1'b0;
            end
        end
    end

    // Combine readiness with the bank guard.
    always_comb begin
        for (int i = 0; i < NUM_ENT; i++)
            eligible[i] = ent_valid[i] && ent_ready[i]
                          && (!bank_locked[ent_bank[i]] || is_head[i]);
    end
endmodule

// File: rtl/fq_min_pick.sv
// Module: smallest-key selector over qualifying slots.
// Assumes keys are unique, so the winner is unambiguous.
module fq_min_pick #(
    parameter int NUM_ENT = 8,
    parameter int KEY_W   = 16,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0]            eligible,
    input  logic [NUM_ENT-1:0][KEY_W-1:0] ent_key,
    output logic                          found,
    output logic [IDX_W-1:0]              win_idx
);
    logic [KEY_W-1:0] best;

    // Linear scan keeping the smallest key seen.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        best    = '1;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (eligible[i] && (!found || ent_key[i] < best)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                best    = ent_key[i];
            end
        end
    end
endmodule

// File: rtl/fq_cmd_arbiter.sv
// Module: fair-queuing DRAM command arbiter (top).
// Issues the qualifying slot with the smallest {deadline, thread, arrival,
// index} key. Bank lock state comes from its own grants. Ready flags and
// deadlines come from outside. The grant is combinational in the same cycle.
module fq_cmd_arbiter #(
    parameter int NUM_ENT   = 8,
    parameter int NUM_BANKS = 8,
    parameter int THREAD_W  = 2,
    parameter int ROW_W     = 8,
    parameter int TS_W      = 8,
    parameter int DL_W      = 10,
    parameter int TRAS      = 18,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int IDX_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int KEY_W    = DL_W + THREAD_W + TS_W + IDX_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_ENT-1:0]                 ent_valid,
    input  logic [NUM_ENT-1:0]                 ent_ready,
    input  logic [NUM_ENT-1:0][THREAD_W-1:0]   ent_thread,
    input  logic [NUM_ENT-1:0][BANK_W-1:0]     ent_bank,
    input  logic [NUM_ENT-1:0][ROW_W-1:0]      ent_row,
    input  logic [NUM_ENT-1:0][1:0]            ent_cmd,
    input  logic [NUM_ENT-1:0][TS_W-1:0]       ent_arrival,
    input  logic [NUM_ENT-1:0][DL_W-1:0]       ent_deadline,
    output logic                               grant_valid,
    output logic [NUM_ENT-1:0]                 grant_onehot,
    output logic [IDX_W-1:0]                   grant_idx,
    output logic [1:0]                         grant_cmd,
    output logic [BANK_W-1:0]                  grant_bank,
    output logic [ROW_W-1:0]                   grant_row,
    output logic [THREAD_W-1:0]                grant_thread
);
    logic [NUM_ENT-1:0][KEY_W-1:0] key;
    logic [NUM_BANKS-1:0]          locked;
    logic [NUM_ENT-1:0]            eligible;
    logic                          found;
    logic [IDX_W-1:0]              win;

    // Build the priority key per slot; the lower value is served first.
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_key
        assign key[i] = {ent_deadline[i], ent_thread[i], ent_arrival[i], IDX_W'(i)};
    end

    fq_bank_age #(.NUM_BANKS(NUM_BANKS), .TRAS(TRAS)) u_age (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(grant_valid), .upd_bank(grant_bank), .upd_cmd(grant_cmd),
        .bank_locked(locked)
    );

    fq_entry_filter #(.NUM_ENT(NUM_ENT), .NUM_BANKS(NUM_BANKS), .KEY_W(KEY_W)) u_filt (
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_bank(ent_bank),
        .ent_key(key), .bank_locked(locked), .eligible(eligible)
    );

    fq_min_pick #(.NUM_ENT(NUM_ENT), .KEY_W(KEY_W)) u_pick (
        .eligible(eligible), .ent_key(key), .found(found), .win_idx(win)
    );

    // Drive the grant outputs from the selected slot.
    always_comb begin
        grant_valid  = found;
        grant_idx    = win;
        grant_onehot = found ? (NUM_ENT'(1) << win) : '0;
        grant_cmd    = ent_cmd[win];
        grant_bank   = ent_bank[win];
        grant_row    = ent_row[win];
        grant_thread = ent_thread[win];
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $countones(grant_onehot) == 1);

    // R1
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ent_valid & ent_ready) == '0) |-> (!grant_valid && grant_onehot == '0));

    // R6
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((grant_onehot & ent_valid & ent_ready) != '0));
endmodule

// File: tb/fq_cmd_arbiter_test.sv
module fq_cmd_arbiter_test;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]            vld, rdy;
    logic [N-1:0][1:0]       thr;
    logic [N-1:0][2:0]       bnk;
    logic [N-1:0][7:0]       row;
    logic [N-1:0][1:0]       cmd;
    logic [N-1:0][7:0]       arr;
    logic [N-1:0][9:0]       dl;

    logic       g_v;
    logic [N-1:0] g_oh;
    logic [2:0] g_idx;
    logic [1:0] g_cmd;
    logic [2:0] g_bank;
    logic [7:0] g_row;
    logic [1:0] g_thr;

    fq_cmd_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(vld), .ent_ready(rdy), .ent_thread(thr), .ent_bank(bnk),
        .ent_row(row), .ent_cmd(cmd), .ent_arrival(arr), .ent_deadline(dl),
        .grant_valid(g_v), .grant_onehot(g_oh), .grant_idx(g_idx),
        .grant_cmd(g_cmd), .grant_bank(g_bank), .grant_row(g_row),
        .grant_thread(g_thr)
    );

    typedef struct {
        logic  v;
        int    idx;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // staged slot values, applied after a falling edge
    logic [N-1:0]      s_vld, s_rdy;
    logic [N-1:0][1:0] s_thr, s_cmd;
    logic [N-1:0][2:0] s_bnk;
    logic [N-1:0][7:0] s_row, s_arr;
    logic [N-1:0][9:0] s_dl;

    task automatic clear_stage();
        s_vld = '0; s_rdy = '0; s_thr = '0; s_cmd = '0;
        s_bnk = '0; s_row = '0; s_arr = '0; s_dl = '0;
    endtask

    task automatic put(int i, bit r, int t, int b, int rw, int c, int a, int d);
        s_vld[i] = 1'b1; s_rdy[i] = r; s_thr[i] = 2'(t); s_bnk[i] = 3'(b);
        s_row[i] = 8'(rw); s_cmd[i] = 2'(c); s_arr[i] = 8'(a); s_dl[i] = 10'(d);
    endtask

    // driver: apply one cycle of stimulus, optionally queue an expectation
    task automatic cyc(bit chk, bit ev, int eidx, string tag);
        exp_t e;
        @(negedge clk);
        #1;
        vld = s_vld; rdy = s_rdy; thr = s_thr; bnk = s_bnk;
        row = s_row; cmd = s_cmd; arr = s_arr; dl = s_dl;
        if (chk) begin
            e.v = ev; e.idx = eidx; e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    // monitor: compare outputs with queued expectations before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (g_v !== e.v) begin
                    errors++;
                    $display("FAIL %s: grant_valid=%0b expected %0b", e.tag, g_v, e.v);
                end else if (!e.v && g_oh !== '0) begin
                    errors++;
                    $display("FAIL %s: grant_onehot=%b expected 0", e.tag, g_oh);
                end else if (e.v && (g_idx !== 3'(e.idx) || g_oh !== (N'(1) << e.idx))) begin
                    errors++;
                    $display("FAIL %s: grant_idx=%0d onehot=%b expected idx %0d",
                             e.tag, g_idx, g_oh, e.idx);
                end else if (e.v && (g_cmd !== cmd[e.idx] || g_bank !== bnk[e.idx]
                          || g_row !== row[e.idx] || g_thr !== thr[e.idx])) begin
                    errors++;
                    $display("FAIL R2 (%s): fields cmd=%0d bank=%0d row=%0d thr=%0d expected %0d %0d %0d %0d",
                             e.tag, g_cmd, g_bank, g_row, g_thr,
                             cmd[e.idx], bnk[e.idx], row[e.idx], thr[e.idx]);
                end
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_stage();
        vld = '0; rdy = '0; thr = '0; bnk = '0; row = '0; cmd = '0; arr = '0; dl = '0;
        // reset state, R1 and R10
        cyc(1, 0, 0, "R1 reset idle");
        cyc(0, 0, 0, "");
        rst_n = 1'b1;

        // R1: valid but none ready
        clear_stage();
        put(0, 0, 0, 0, 1, 1, 1, 10); put(1, 0, 1, 1, 2, 2, 2, 5);
        cyc(1, 0, 0, "R1 none ready");

        // R3: smallest deadline among ready reads/writes
        clear_stage();
        put(0, 1, 0, 0, 11, 1, 1, 40); put(3, 1, 1, 1, 22, 2, 2, 25);
        put(5, 1, 2, 3, 33, 1, 3, 33);
        cyc(1, 1, 3, "R3 earliest deadline");

        // R3 second pattern: winner in highest slot
        clear_stage();
        put(1, 1, 3, 6, 7, 2, 9, 300); put(7, 1, 0, 6, 8, 1, 9, 12);
        cyc(1, 1, 7, "R3 deadline high slot");

        // R4: equal deadlines, lower thread wins
        clear_stage();
        put(0, 1, 3, 0, 1, 1, 1, 20); put(2, 1, 1, 1, 2, 1, 9, 20);
        put(4, 1, 2, 2, 3, 2, 0, 20);
        cyc(1, 1, 2, "R4 lower thread");

        // R5: equal deadline and thread, older arrival wins
        clear_stage();
        put(1, 1, 2, 0, 1, 1, 9, 30); put(4, 1, 2, 1, 2, 1, 4, 30);
        put(6, 1, 2, 2, 3, 1, 7, 30);
        cyc(1, 1, 4, "R5 older arrival");

        // R5: full tie, lower index wins
        clear_stage();
        put(2, 1, 1, 0, 1, 2, 5, 30); put(6, 1, 1, 1, 2, 2, 5, 30);
        cyc(1, 1, 2, "R5 lower index");

        // R6: not-ready earliest deadline is skipped
        clear_stage();
        put(0, 0, 0, 1, 1, 1, 1, 1); put(5, 1, 3, 2, 2, 2, 2, 50);
        cyc(1, 1, 5, "R6 skip not ready");

        // R7/R8: open bank 2, then watch the lock point
        clear_stage();
        put(0, 1, 0, 2, 44, 0, 0, 60);
        cyc(1, 1, 0, "R7 activate grant");
        clear_stage();
        put(0, 1, 0, 2, 44, 1, 3, 50);   // ready row hit
        put(1, 0, 1, 2, 44, 1, 4, 10);   // earlier deadline, not ready
        for (int k = 0; k <= 18; k++) begin
            if (k == 0)       cyc(1, 1, 0, "R7 unlocked at count 0");
            else if (k == 17) cyc(1, 1, 0, "R7 unlocked at TRAS-1");
            else if (k == 18) cyc(1, 0, 0, "R8 locked bank stalls");
            else              cyc(0, 0, 0, "");
        end
        put(2, 1, 3, 5, 9, 1, 5, 99);
        cyc(1, 1, 2, "R8 other bank served");
        s_vld[2] = 1'b0;
        s_rdy[1] = 1'b1;
        cyc(1, 1, 1, "R8 head served when ready");

        // R9: precharge bank 2, row hit served again
        clear_stage();
        put(3, 1, 0, 2, 44, 3, 6, 70);
        cyc(1, 1, 3, "R9 precharge grant");
        clear_stage();
        put(0, 1, 0, 2, 44, 1, 3, 50); put(1, 0, 1, 2, 44, 1, 4, 10);
        cyc(1, 1, 0, "R9 unlocked after precharge");

        // R10: lock bank 4, then reset clears it
        clear_stage();
        put(0, 1, 0, 4, 17, 0, 0, 80);
        cyc(1, 1, 0, "R10 activate bank 4");
        clear_stage();
        put(0, 1, 0, 4, 17, 2, 1, 60); put(1, 0, 2, 4, 17, 1, 2, 5);
        for (int k = 0; k < 20; k++) cyc(0, 0, 0, "");
        cyc(1, 0, 0, "R8 bank 4 locked before reset");
        rst_n = 1'b0;
        cyc(0, 0, 0, "");
        rst_n = 1'b1;
        cyc(1, 1, 0, "R10 bank closed after reset");

        clear_stage();
        cyc(1, 0, 0, "R1 final idle");
        @(negedge clk);
        #6;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule